// File: doc/BRIEF.md
# Banked cartridge memory mapper

This block sits between an 8-bit CPU with a 16-bit address bus and the memories on a plug-in cartridge. The CPU address space is cut into four 16 KiB windows, chosen by address bits 15:14; bits 13:0 are the offset within a window. Windows 0, 1 and 2 show a selectable 16 KiB bank of ROM. Window 2 can be swapped for one of two 16 KiB RAM banks, and window 3 can be handed to cartridge RAM. The lowest 1 KiB of window 0 always shows the start of ROM, so the reset and interrupt code is reachable whatever bank is selected.

Four registers at the top of the address space hold the mapping. They are written by ordinary CPU writes and do not read back. The block drives the address and strobes of an external asynchronous ROM and RAM and returns their byte on the CPU read bus. A claim output tells the system bus whether the cartridge answered the access, so that other memory, such as console RAM under window 3, can answer when the cartridge does not. Accesses that land past the end of the fitted ROM or RAM are claimed, but they return zero and never strobe the memory.

Top module: `cart_mapper`

## Requirements
- R1: After reset the control register is clear and banks 0, 1 and 2 are selected for windows 0, 1 and 2, so reading 0x4000+n gives ROM byte 0x4000+n, reading 0x8000+n gives ROM byte 0x8000+n, and window 3 is not claimed. When neither read nor write is requested, claim is low.
- R2: A read with offset 0x0000-0x03FF in window 0 returns ROM byte at that offset whatever bank is selected. A read at a higher offset in window 0 returns ROM byte (bank0 * 0x4000 + offset), where bank0 is the full byte last written to address 0xFFFD.
- R3: A read in window 1 returns ROM byte (bank1 * 0x4000 + offset), where bank1 is the byte last written to 0xFFFE.
- R4: A write to 0xFFFC sets the control fields: bit 2 selects the RAM bank for window 2, bit 3 maps RAM into window 2, bit 4 maps RAM into window 3; the other bits have no effect on mapping. A read in window 2 returns RAM byte (bit2 * 0x4000 + offset) when bit 3 is set, and otherwise ROM byte (bank2 * 0x4000 + offset), where bank2 is the byte last written to 0xFFFF.
- R5: A read in window 3 returns RAM byte at the plain offset and is claimed when control bit 4 is set; otherwise it is not claimed and the read bus is 0x00.
- R6: Writes to windows 0 and 1 are never claimed and change no memory.
- R7: A write to window 2 or 3 is claimed and stored in RAM only while that window's RAM mapping bit is set; otherwise it is not claimed and RAM keeps its contents.
- R8: A claimed read whose ROM or RAM byte address lies at or beyond the fitted size returns 0x00 without strobing the memory, and a RAM write beyond the fitted size is claimed but dropped.
- R9: A write to 0xFFFC-0xFFFF updates its register for the following access and, when window 3 RAM is mapped at that moment, is also stored in RAM at offset 0x3FFC-0x3FFF and claimed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 16 | CPU address |
| cpu_rd | input | 1 | CPU read request |
| cpu_wr | input | 1 | CPU write request |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | Read data returned to the CPU, 0x00 when nothing is read |
| cpu_claim | output | 1 | The cartridge answers this access |
| rom_addr | output | ROM_AW | ROM byte address |
| rom_re | output | 1 | ROM read strobe, only for in-range addresses |
| rom_data | input | 8 | ROM byte at rom_addr |
| ram_addr | output | RAM_AW | RAM byte address |
| ram_re | output | 1 | RAM read strobe, only for in-range addresses |
| ram_we | output | 1 | RAM write strobe, only for in-range addresses |
| ram_wdata | output | 8 | RAM write data |
| ram_rdata | input | 8 | RAM byte at ram_addr |

## Verification
The bench builds the mapper with 80 KiB of ROM, five whole banks, so a bank number of 5 or above in any window falls off the end and exercises the zero-return path. RAM is set to 0x4100 bytes, which keeps offsets 0x3FFC-0x3FFF of the first bank valid for the register write-through case while leaving only the first 256 bytes of the second bank in range, so both the in-range and out-of-range sides of the RAM bound are reachable through window 2. The memories are modelled sparsely and the expected bytes come from a behavioural model of the mapping registers and a separate copy of the expected RAM contents.

// File: rtl/cart_map_pkg.sv
package cart_map_pkg;
  localparam int CPU_AW     = 16;
  localparam int OFF_W      = 14;
  localparam int BANK_W     = 8;
  localparam int FIXED_W    = 10;
  localparam int NUM_BANKS  = 3;
  localparam int ROM_FULL_W = OFF_W + BANK_W;
  localparam int RAM_FULL_W = OFF_W + 1;

  localparam logic [CPU_AW-1:0] REG_CTRL  = 16'hFFFC;
  localparam logic [CPU_AW-1:0] REG_BANK0 = 16'hFFFD;

  typedef struct packed {
    logic ram_bank2;
    logic ram_en2;
    logic ram_en3;
  } ctrl_t;

  typedef logic [NUM_BANKS-1:0][BANK_W-1:0] bank_arr_t;

  typedef enum logic [1:0] {
    TGT_NONE = 2'd0,
    TGT_ROM  = 2'd1,
    TGT_RAM  = 2'd2
  } tgt_t;
endpackage

// File: rtl/cart_map_regs.sv
module cart_map_regs
  import cart_map_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [CPU_AW-1:0] addr,
  input  logic [7:0]        wdata,
  output ctrl_t             ctrl,
  output bank_arr_t         banks
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl <= '0;
    end else if (wr && addr == REG_CTRL) begin
      ctrl <= '{ram_bank2: wdata[2], ram_en2: wdata[3], ram_en3: wdata[4]};
    end
  end

  for (genvar i = 0; i < NUM_BANKS; i++) begin : g_bank
    logic [BANK_W-1:0] bank_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        bank_q <= BANK_W'(i);
      end else if (wr && addr == REG_BANK0 + CPU_AW'(i)) begin
        bank_q <= wdata;
      end
    end
    assign banks[i] = bank_q;
  end
endmodule

// File: rtl/cart_map_decode.sv
module cart_map_decode
  import cart_map_pkg::*;
(
  input  logic [CPU_AW-1:0]     addr,
  input  ctrl_t                 ctrl,
  input  bank_arr_t             banks,
  output tgt_t                  tgt,
  output logic [ROM_FULL_W-1:0] rom_full,
  output logic [RAM_FULL_W-1:0] ram_full
);
  logic [1:0]       page;
  logic [OFF_W-1:0] off;
  logic             fixed_hit;

  assign page      = addr[CPU_AW-1:OFF_W];
  assign off       = addr[OFF_W-1:0];
  assign fixed_hit = (off[OFF_W-1:FIXED_W] == '0);

  always_comb begin
    tgt      = TGT_NONE;
    rom_full = '0;
    ram_full = '0;
    unique case (page)
      2'd0: begin
        tgt      = TGT_ROM;
        rom_full = fixed_hit ? {{BANK_W{1'b0}}, off} : {banks[0], off};
      end
      2'd1: begin
        tgt      = TGT_ROM;
        rom_full = {banks[1], off};
      end
      2'd2: begin
        if (ctrl.ram_en2) begin
          tgt      = TGT_RAM;
          ram_full = {ctrl.ram_bank2, off};
        end else begin
          tgt      = TGT_ROM;
          rom_full = {banks[2], off};
        end
      end
      default: begin
        if (ctrl.ram_en3) begin
          tgt      = TGT_RAM;
          ram_full = {1'b0, off};
        end
      end
    endcase
  end
endmodule

// File: rtl/cart_mapper.sv
module cart_mapper
  import cart_map_pkg::*;
#(
  parameter int ROM_BYTES = 262144,
  parameter int RAM_BYTES = 32768,
  localparam int ROM_AW   = $clog2(ROM_BYTES),
  localparam int RAM_AW   = $clog2(RAM_BYTES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CPU_AW-1:0] cpu_addr,
  input  logic              cpu_rd,
  input  logic              cpu_wr,
  input  logic [7:0]        cpu_wdata,
  output logic [7:0]        cpu_rdata,
  output logic              cpu_claim,
  output logic [ROM_AW-1:0] rom_addr,
  output logic              rom_re,
  input  logic [7:0]        rom_data,
  output logic [RAM_AW-1:0] ram_addr,
  output logic              ram_re,
  output logic              ram_we,
  output logic [7:0]        ram_wdata,
  input  logic [7:0]        ram_rdata
);
  ctrl_t                 ctrl;
  bank_arr_t             banks;
  tgt_t                  tgt;
  logic [ROM_FULL_W-1:0] rom_full;
  logic [RAM_FULL_W-1:0] ram_full;
  logic                  rom_ok;
  logic                  ram_ok;

  cart_map_regs u_regs (
    .clk   (clk),
    .rst   (rst),
    .wr    (cpu_wr),
    .addr  (cpu_addr),
    .wdata (cpu_wdata),
    .ctrl  (ctrl),
    .banks (banks)
  );

  cart_map_decode u_decode (
    .addr     (cpu_addr),
    .ctrl     (ctrl),
    .banks    (banks),
    .tgt      (tgt),
    .rom_full (rom_full),
    .ram_full (ram_full)
  );

  assign rom_ok = (32'(rom_full) < ROM_BYTES);
  assign ram_ok = (32'(ram_full) < RAM_BYTES);

  assign rom_addr  = rom_full[ROM_AW-1:0];
  assign ram_addr  = ram_full[RAM_AW-1:0];
  assign ram_wdata = cpu_wdata;

  assign rom_re = cpu_rd && (tgt == TGT_ROM) && rom_ok;
  assign ram_re = cpu_rd && (tgt == TGT_RAM) && ram_ok;
  assign ram_we = cpu_wr && (tgt == TGT_RAM) && ram_ok;

  assign cpu_claim = (cpu_rd && (tgt != TGT_NONE)) || (cpu_wr && (tgt == TGT_RAM));

  always_comb begin
    if (rom_re)      cpu_rdata = rom_data;
    else if (ram_re) cpu_rdata = ram_rdata;
    else             cpu_rdata = 8'h00;
  end
endmodule

// File: rtl/cart_mapper_chk.sv
module cart_mapper_chk #(
  parameter int ROM_BYTES = 262144,
  parameter int RAM_BYTES = 32768,
  localparam int ROM_AW   = $clog2(ROM_BYTES),
  localparam int RAM_AW   = $clog2(RAM_BYTES)
) (
  input logic              clk,
  input logic              rst,
  input logic [15:0]       cpu_addr,
  input logic              cpu_rd,
  input logic              cpu_wr,
  input logic [7:0]        cpu_rdata,
  input logic              cpu_claim,
  input logic [ROM_AW-1:0] rom_addr,
  input logic              rom_re,
  input logic [RAM_AW-1:0] ram_addr,
  input logic              ram_re,
  input logic              ram_we
);
  // R6: low windows never take a write
  assert_lowpage_write_R6: assert property (@(posedge clk) disable iff (rst)
    (cpu_wr && !cpu_addr[15]) |-> (!ram_we && !cpu_claim));

  // R8: RAM strobes only inside the fitted size
  assert_ram_bound_R8: assert property (@(posedge clk) disable iff (rst)
    (ram_we || ram_re) |-> (32'(ram_addr) < RAM_BYTES));

  // R8: ROM is only ever read, and never together with RAM
  assert_rom_strobe_R8: assert property (@(posedge clk) disable iff (rst)
    rom_re |-> (cpu_rd && !ram_re && !ram_we));

  // R5: an unanswered read leaves the bus at zero
  assert_unclaimed_zero_R5: assert property (@(posedge clk) disable iff (rst)
    (cpu_rd && !cpu_claim) |-> (cpu_rdata == 8'h00));

  // R2: the first KiB is never banked
  assert_fixed_window_R2: assert property (@(posedge clk) disable iff (rst)
    (cpu_rd && cpu_addr[15:10] == 6'd0) |-> (rom_addr == ROM_AW'(cpu_addr[9:0])));

  // R5: window 3 RAM uses the plain offset
  assert_page3_offset_R5: assert property (@(posedge clk) disable iff (rst)
    ((ram_we || ram_re) && cpu_addr[15:14] == 2'b11) |-> (ram_addr == RAM_AW'(cpu_addr[13:0])));
endmodule

bind cart_mapper cart_mapper_chk #(.ROM_BYTES(ROM_BYTES), .RAM_BYTES(RAM_BYTES)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cpu_addr  (cpu_addr),
  .cpu_rd    (cpu_rd),
  .cpu_wr    (cpu_wr),
  .cpu_rdata (cpu_rdata),
  .cpu_claim (cpu_claim),
  .rom_addr  (rom_addr),
  .rom_re    (rom_re),
  .ram_addr  (ram_addr),
  .ram_re    (ram_re),
  .ram_we    (ram_we)
);

// File: tb/cart_mapper_test.sv
module cart_mapper_test;
  localparam int ROM_B  = 'h14000;
  localparam int RAM_B  = 'h4100;
  localparam int ROM_AW = $clog2(ROM_B);
  localparam int RAM_AW = $clog2(RAM_B);

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [15:0]       cpu_addr = 16'h0;
  logic              cpu_rd = 1'b0;
  logic              cpu_wr = 1'b0;
  logic [7:0]        cpu_wdata = 8'h0;
  logic [7:0]        cpu_rdata;
  logic              cpu_claim;
  logic [ROM_AW-1:0] rom_addr;
  logic              rom_re;
  logic [7:0]        rom_data = 8'hEE;
  logic [RAM_AW-1:0] ram_addr;
  logic              ram_re;
  logic              ram_we;
  logic [7:0]        ram_wdata;
  logic [7:0]        ram_rdata = 8'hEE;

  int errors = 0;
  int checks = 0;

  logic [7:0] phys_mem [int];
  logic [7:0] model_mem [int];
  int m_bank0, m_bank1, m_bank2;
  bit m_en2, m_en3, m_rbank;

  always #10 clk = ~clk;

  cart_mapper #(.ROM_BYTES(ROM_B), .RAM_BYTES(RAM_B)) uut (
    .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_claim(cpu_claim),
    .rom_addr(rom_addr), .rom_re(rom_re), .rom_data(rom_data),
    .ram_addr(ram_addr), .ram_re(ram_re), .ram_we(ram_we),
    .ram_wdata(ram_wdata), .ram_rdata(ram_rdata)
  );

  always @(posedge clk) if (ram_we) phys_mem[int'(ram_addr)] = ram_wdata;

  function automatic logic [7:0] rom_fn(input int a);
    return 8'((a ^ (a >> 7) ^ (a >> 13)) + 'h5B);
  endfunction

  function automatic logic [7:0] peek(ref logic [7:0] m [int], input int k);
    return m.exists(k) ? m[k] : 8'h00;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp, input string what);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // kind: 0 none, 1 rom, 2 ram
  task automatic predict(input int a, input bit w, output int kind, output int idx);
    int page = a >> 14;
    int off  = a & 16'h3FFF;
    kind = 0; idx = 0;
    case (page)
      0: begin kind = 1; idx = (off < 1024) ? off : m_bank0 * 16384 + off; end
      1: begin kind = 1; idx = m_bank1 * 16384 + off; end
      2: if (m_en2) begin kind = 2; idx = int'(m_rbank) * 16384 + off; end
         else begin kind = 1; idx = m_bank2 * 16384 + off; end
      default: if (m_en3) begin kind = 2; idx = off; end
    endcase
    if (w && kind == 1) kind = 0;
  endtask

  task automatic access(input int a, input bit w, input int d, input string req);
    int kind, idx;
    logic [7:0] exp_data;
    @(negedge clk);
    cpu_addr = 16'(a); cpu_wr = w; cpu_rd = !w; cpu_wdata = 8'(d);
    #2;
    rom_data  = rom_re ? rom_fn(int'(rom_addr)) : 8'hEE;
    ram_rdata = ram_re ? peek(phys_mem, int'(ram_addr)) : 8'hEE;
    #2;
    predict(a, w, kind, idx);
    chk(cpu_claim == (kind != 0), req, int'(cpu_claim), int'(kind != 0), $sformatf("claim @%04h", a));
    if (!w) begin
      exp_data = 8'h00;
      if (kind == 1 && idx < ROM_B) exp_data = rom_fn(idx);
      if (kind == 2 && idx < RAM_B) exp_data = peek(model_mem, idx);
      chk(cpu_rdata == exp_data, req, int'(cpu_rdata), int'(exp_data), $sformatf("rdata @%04h", a));
    end
    @(posedge clk);
    #1;
    if (w) begin
      if (kind == 2 && idx < RAM_B) model_mem[idx] = 8'(d);
      if (a == 'hFFFC) begin m_rbank = d[2]; m_en2 = d[3]; m_en3 = d[4]; end
      if (a == 'hFFFD) m_bank0 = d & 'hFF;
      if (a == 'hFFFE) m_bank1 = d & 'hFF;
      if (a == 'hFFFF) m_bank2 = d & 'hFF;
    end
  endtask

  task automatic idle(input string req);
    @(negedge clk);
    cpu_rd = 1'b0; cpu_wr = 1'b0; cpu_addr = 16'hC000;
    #4;
    chk(cpu_claim == 1'b0, req, int'(cpu_claim), 0, "idle claim");
    chk(cpu_rdata == 8'h00, req, int'(cpu_rdata), 0, "idle rdata");
  endtask

  initial begin
    #(20 * 100000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    m_bank0 = 0; m_bank1 = 1; m_bank2 = 2; m_en2 = 0; m_en3 = 0; m_rbank = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;

    // R1 reset mapping
    access('h4100, 0, 0, "R1");
    access('h8010, 0, 0, "R1");
    access('hC000, 0, 0, "R1");
    idle("R1");
    // R7 writes to unmapped windows 2/3 dropped
    access('h8000, 1, 'h99, "R7");
    access('hC005, 1, 'h11, "R7");
    // R2 fixed first KiB, banked rest
    access('h0010, 0, 0, "R2");
    access('hFFFD, 1, 3, "R2");
    access('h0005, 0, 0, "R2");
    access('h03FF, 0, 0, "R2");
    access('h0400, 0, 0, "R2");
    access('h3FFF, 0, 0, "R2");
    // R3 window 1 banking
    access('hFFFE, 1, 4, "R3");
    access('h4001, 0, 0, "R3");
    for (int i = 0; i < 5; i++) begin
      access('hFFFE, 1, i, "R3");
      access('h4000 + i * 'h111, 0, 0, "R3");
    end
    access('hFFFE, 1, 5, "R8");
    access('h4000, 0, 0, "R8");
    // R4 window 2 ROM then RAM banks
    access('hFFFF, 1, 4, "R4");
    access('h8123, 0, 0, "R4");
    access('hFFFC, 1, 'h08, "R4");
    access('h8010, 1, 'hA5, "R7");
    access('h8010, 0, 0, "R4");
    access('h8000, 0, 0, "R7");
    access('hFFFC, 1, 'hEC, "R4");
    access('h8020, 1, 'h5A, "R7");
    access('h8020, 0, 0, "R4");
    access('h80FF, 1, 'hC3, "R8");
    access('h80FF, 0, 0, "R8");
    access('h8100, 1, 'h77, "R8");
    access('h8100, 0, 0, "R8");
    access('hFFFC, 1, 'h08, "R4");
    access('h8020, 0, 0, "R4");
    // R6 writes to windows 0/1 ignored
    access('h1234, 1, 'h77, "R6");
    access('h5234, 1, 'h66, "R6");
    access('h9234, 0, 0, "R6");
    access('h4234, 0, 0, "R6");
    // R5 window 3 RAM
    access('hFFFC, 1, 'h10, "R5");
    access('hC010, 0, 0, "R5");
    access('hC100, 1, 'h3C, "R5");
    access('hC100, 0, 0, "R5");
    access('hC005, 0, 0, "R7");
    access('h8010, 0, 0, "R4");
    // R9 register writes fall through to window 3 RAM
    access('hFFFF, 1, 1, "R9");
    access('hFFFF, 0, 0, "R9");
    access('h8000, 0, 0, "R9");
    access('hFFFD, 1, 2, "R9");
    access('h0400, 0, 0, "R9");
    access('hFFFD, 0, 0, "R9");
    access('hFFFC, 1, 'h00, "R9");
    access('hC000, 0, 0, "R5");
    access('hFFFC, 0, 0, "R5");
    // R8 far bank
    access('hFFFE, 1, 'hFF, "R8");
    access('h4000, 0, 0, "R8");
    idle("R1");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule